// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a bus-mapped watchdog. An up-counter advances on a slow timing strobe, either on every strobe or once every 2^N strobes through an optional divider. When the counter rolls over from all-ones it raises a one-cycle reset request and restarts from a software-set load value. Software keeps the system alive by writing a trigger value that differs from the last one it wrote. Each such write copies the load value into the counter.

The counter only starts or stops after a two-word key sequence is written to a dedicated key register. A wrong second word, or a second word that does not directly follow its first word, leaves the run state unchanged. Every bus write is posted: it takes effect a fixed number of clock cycles after the bus cycle. A status register shows, per register, which writes are still in flight. While the counter runs, the divider configuration and the load value are frozen.

The word-indexed map is: 0 revision, 1 control, 2 counter (read-only), 3 load, 4 trigger, 5 key, 6 pending status. Address 7 and the key register read as zero. Writes to addresses 0, 2, 6 and 7 are dropped.

Top module: `keyed_wdt`

## Requirements
- R1: Writing 0xBBBB to the key register, followed by 0x4444 as the next key-register write, puts the counter in the running state.
- R2: Writing 0xAAAA to the key register, followed by 0x5555 as the next key-register write, stops the counter, which then holds its value.
- R3: A key sequence whose second word is wrong, or whose second word is not directly preceded by its first word among key-register writes, is discarded, and the run state is unchanged.
- R4: When a trigger write takes effect with a value different from the last applied trigger value, the counter is loaded with the load register and the prescaler phase restarts. A trigger write with the same value changes nothing. The trigger register reads back the last applied value.
- R5: Status bit 0 (control), bit 2 (load), bit 3 (trigger) and bit 4 (key) are set from the cycle after the bus write until the clock edge POST_DLY cycles after it, when the write takes effect. A write to a register whose pending bit is set is dropped.
- R6: Control bit 5 enables the prescaler and bits 4:2 hold the ratio N. With the prescaler enabled, the running counter advances once per 2^N tick strobes; with it disabled, it advances on every tick strobe.
- R7: The counter reads back at address 2 at any time, counts upward while running, and holds while stopped, except for a trigger reload.
- R8: Control and load writes that take effect while the counter runs are ignored.
- R9: When a counter step leaves the all-ones value, wdt_rst_o pulses high for exactly one cycle and the counter is reloaded from the load register.
- R10: Address 0 reads REV_CODE in bits 7:0, with all upper bits zero.
- R11: After reset the counter, load, control, trigger and status registers read zero, and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timing strobe, one cycle per slow-clock tick |
| bus_we | input | 1 | Write strobe for bus_addr |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| wdt_rst_o | output | 1 | One-cycle reset request on counter overflow |

## Verification
On every cycle, the assertions enforce several rules: the reset pulse appears only while the counter was running and comes with a reload, the counter holds while stopped unless a trigger lands, the configuration stays frozen during a run, the run state changes only when a key write takes effect, and pending bits stay set until their write lands. Other behaviour can only be shown by the bench scenarios. These cover whether a key pair is accepted or discarded, whether a repeated trigger value is ignored, the exact count per prescaler window, the dropping of a write that collides with a pending one, and the cycle at which each posted write appears. The behavioural reference model compares the read port and the reset output on every clock.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int POST_DLY = 3,
  parameter logic [7:0] REV_CODE = 8'h51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_o
);
  localparam int RATIO_W = 3;
  localparam int PRE_W   = 1 << RATIO_W;
  localparam int DLY_W   = (POST_DLY < 2) ? 1 : $clog2(POST_DLY);
  localparam int NSLOT   = 4;
  localparam int S_CTRL = 0, S_LOAD = 1, S_TRIG = 2, S_KEY = 3;
  localparam logic [2:0] A_REV = 3'd0, A_CTRL = 3'd1, A_CNT = 3'd2, A_LOAD = 3'd3,
                         A_TRIG = 3'd4, A_KEY = 3'd5, A_STAT = 3'd6;
  localparam logic [DATA_W-1:0] K_GO1 = DATA_W'(16'hBBBB), K_GO2 = DATA_W'(16'h4444),
                                K_HALT1 = DATA_W'(16'hAAAA), K_HALT2 = DATA_W'(16'h5555);

  typedef enum logic [1:0] {ARM_NONE, ARM_GO, ARM_HALT} arm_t;

  logic [NSLOT-1:0]  pend, due, wr_hit;
  logic [DLY_W-1:0]  dly  [NSLOT];
  logic [DATA_W-1:0] pdat [NSLOT];

  assign wr_hit[S_CTRL] = bus_we && bus_addr == A_CTRL;
  assign wr_hit[S_LOAD] = bus_we && bus_addr == A_LOAD;
  assign wr_hit[S_TRIG] = bus_we && bus_addr == A_TRIG;
  assign wr_hit[S_KEY]  = bus_we && bus_addr == A_KEY;

  for (genvar i = 0; i < NSLOT; i++) begin : g_post
    assign due[i] = pend[i] && dly[i] == '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        dly[i]  <= '0;
        pdat[i] <= '0;
      end else if (due[i]) begin
        pend[i] <= 1'b0;
      end else if (pend[i]) begin
        dly[i] <= dly[i] - 1'b1;
      end else if (wr_hit[i]) begin
        pend[i] <= 1'b1;
        dly[i]  <= DLY_W'(POST_DLY - 1);
        pdat[i] <= bus_wdata;
      end
    end
  end

  logic               run, pre_en;
  logic [RATIO_W-1:0] ratio;
  logic [CNT_W-1:0]   cnt, load_q;
  logic [DATA_W-1:0]  last_trig;
  logic [PRE_W-1:0]   presc, pre_top;
  arm_t               armed;
  logic               reload, step, wrap;

  assign pre_top = (PRE_W'(1) << ratio) - 1'b1;
  assign reload  = due[S_TRIG] && pdat[S_TRIG] != last_trig;
  assign step    = run && tick && !reload && (!pre_en || presc == pre_top);
  assign wrap    = step && &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en <= 1'b0;
      ratio  <= '0;
      load_q <= '0;
    end else if (!run) begin
      if (due[S_CTRL]) {pre_en, ratio} <= pdat[S_CTRL][5:2];
      if (due[S_LOAD]) load_q <= pdat[S_LOAD][CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      armed <= ARM_NONE;
    end else if (due[S_KEY]) begin
      armed <= ARM_NONE;
      if (pdat[S_KEY] == K_GO1) armed <= ARM_GO;
      else if (pdat[S_KEY] == K_HALT1) armed <= ARM_HALT;
      else if (armed == ARM_GO && pdat[S_KEY] == K_GO2) run <= 1'b1;
      else if (armed == ARM_HALT && pdat[S_KEY] == K_HALT2) run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      last_trig <= '0;
      presc     <= '0;
      wdt_rst_o <= 1'b0;
    end else begin
      wdt_rst_o <= wrap;
      if (reload) begin
        cnt       <= load_q;
        last_trig <= pdat[S_TRIG];
      end else if (step) begin
        cnt <= wrap ? load_q : cnt + 1'b1;
      end
      if (!run || reload || !pre_en) presc <= '0;
      else if (tick) presc <= (presc == pre_top) ? '0 : presc + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REV:  bus_rdata = DATA_W'(REV_CODE);
      A_CTRL: bus_rdata = DATA_W'({pre_en, ratio, 2'b00});
      A_CNT:  bus_rdata = DATA_W'(cnt);
      A_LOAD: bus_rdata = DATA_W'(load_q);
      A_TRIG: bus_rdata = last_trig;
      A_STAT: bus_rdata = DATA_W'({pend[S_KEY], pend[S_TRIG], pend[S_LOAD], 1'b0, pend[S_CTRL]});
      default: bus_rdata = '0;
    endcase
  end

  AST_RST_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> $past(run)); // R9
  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> cnt == load_q); // R9
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(due[S_TRIG])) |-> $stable(cnt)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ($stable(load_q) && $stable(pre_en) && $stable(ratio))); // R8
  AST_RUN_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) || $fell(run)) |-> $past(due[S_KEY])); // R1 R2 R3
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend[S_LOAD]) && !$past(due[S_LOAD])) |-> pend[S_LOAD]); // R5
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CLK_P = 10;
  localparam int D = 3;
  localparam logic [7:0] REV = 8'h51;

  logic clk = 0, rst_n = 0, tick = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic wdt_rst_o;
  int checks = 0, errors = 0, rst_seen = 0, tick_mode = 0;
  logic prev_rst = 0;
  bit done = 0;

  keyed_wdt #(.DATA_W(32), .CNT_W(32), .POST_DLY(D), .REV_CODE(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o));

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  longint cyc = 0;
  bit m_run, m_en, m_rst;
  int m_ratio, m_presc, m_arm;
  logic [31:0] m_cnt, m_load, m_last;
  bit m_pend[4];
  longint m_due[4];
  logic [31:0] m_dat[4];

  function automatic int slot_of(input logic [2:0] a);
    case (a)
      3'd1: return 0;
      3'd3: return 1;
      3'd4: return 2;
      3'd5: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {24'h0, REV};
      3'd1: return (32'(m_en) << 5) | (32'(m_ratio) << 2);
      3'd2: return m_cnt;
      3'd3: return m_load;
      3'd4: return m_last;
      3'd6: return 32'(m_pend[0]) | (32'(m_pend[1]) << 2) | (32'(m_pend[2]) << 3) | (32'(m_pend[3]) << 4);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_en = 0; m_ratio = 0; m_presc = 0; m_arm = 0; m_rst = 0;
      m_cnt = 0; m_load = 0; m_last = 0;
      for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_due[i] = 0; m_dat[i] = 0; end
    end else begin
      bit o_run, o_en, reload, o_pend[4];
      int o_ratio, s;
      logic [31:0] o_load, o_cnt;
      cyc++;
      o_run = m_run; o_en = m_en; o_ratio = m_ratio; o_load = m_load; o_cnt = m_cnt;
      for (int i = 0; i < 4; i++) o_pend[i] = m_pend[i];
      reload = 0; m_rst = 0;
      if (m_pend[0] && m_due[0] == cyc) begin
        m_pend[0] = 0;
        if (!o_run) begin m_en = m_dat[0][5]; m_ratio = int'(m_dat[0][4:2]); end
      end
      if (m_pend[1] && m_due[1] == cyc) begin
        m_pend[1] = 0;
        if (!o_run) m_load = m_dat[1];
      end
      if (m_pend[3] && m_due[3] == cyc) begin
        m_pend[3] = 0;
        if (m_dat[3] == 32'hBBBB) m_arm = 1;
        else if (m_dat[3] == 32'hAAAA) m_arm = 2;
        else begin
          if (m_arm == 1 && m_dat[3] == 32'h4444) m_run = 1;
          if (m_arm == 2 && m_dat[3] == 32'h5555) m_run = 0;
          m_arm = 0;
        end
      end
      if (m_pend[2] && m_due[2] == cyc) begin
        m_pend[2] = 0;
        if (m_dat[2] != m_last) begin
          m_last = m_dat[2]; m_cnt = o_load; m_presc = 0; reload = 1;
        end
      end
      if (!o_run || !o_en) m_presc = 0;
      if (o_run && tick && !reload) begin
        bit adv;
        adv = 0;
        if (!o_en) adv = 1;
        else if (m_presc == (1 << o_ratio) - 1) begin adv = 1; m_presc = 0; end
        else m_presc++;
        if (adv) begin
          if (o_cnt == 32'hFFFF_FFFF) begin m_cnt = o_load; m_rst = 1; end
          else m_cnt = o_cnt + 1;
        end
      end
      s = slot_of(bus_addr);
      if (bus_we && s >= 0 && !o_pend[s]) begin
        m_pend[s] = 1; m_due[s] = cyc + D; m_dat[s] = bus_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R10";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R4";
      3'd6: return "R5";
      default: return "R3";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_of(bus_addr), bus_rdata, m_read(bus_addr));
      chk("R9", 32'(wdt_rst_o), 32'(m_rst));
      if (wdt_rst_o) begin
        rst_seen++;
        if (prev_rst) chk("R9 pulse width", 32'd2, 32'd1);
      end
      prev_rst = wdt_rst_o;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick = (tick_mode == 0) ? 1'b1 : lfsr[0];
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0; bus_addr = 3'd2;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic key(input logic [31:0] w1, input logic [31:0] w2);
    wr(3'd5, w1); idle(D + 1);
    wr(3'd5, w2); idle(D + 1);
  endtask

  initial begin
    logic [31:0] v, a, b;
    idle(3);
    rst_n = 1;
    idle(1);
    // R11 / R10 reset state
    rd(3'd2, v); chk("R11 counter", v, 0);
    rd(3'd6, v); chk("R11 status", v, 0);
    rd(3'd1, v); chk("R11 control", v, 0);
    rd(3'd0, v); chk("R10 revision", v, {24'h0, REV});
    // R5 pending timing on load write
    wr(3'd3, 32'h100);
    rd(3'd6, v); chk("R5 load pending", v, 32'h4);
    rd(3'd6, v); chk("R5 load pending", v, 32'h4);
    rd(3'd6, v); chk("R5 load cleared", v, 32'h0);
    rd(3'd3, v); chk("R5 load applied", v, 32'h100);
    // R4 trigger reload while stopped
    wr(3'd4, 32'h1234); idle(D + 1);
    rd(3'd2, v); chk("R4 reload", v, 32'h100);
    rd(3'd2, v); chk("R7 stopped hold", v, 32'h100);
    // R6 prescaler ratio 2
    wr(3'd1, 32'h28); idle(D + 1);
    rd(3'd1, v); chk("R6 control", v, 32'h28);
    // R1 start
    tick_mode = 0;
    key(32'hBBBB, 32'h4444);
    rd(3'd2, a); idle(39); rd(3'd2, b);
    chk("R6 divide by 4 over 40 ticks", b - a, 32'd10);
    chk("R1 running", 32'(b > 32'h100), 1);
    // R8 config locked
    wr(3'd3, 32'h5); idle(D + 1);
    rd(3'd3, v); chk("R8 load frozen", v, 32'h100);
    wr(3'd1, 32'h0); idle(D + 1);
    rd(3'd1, v); chk("R8 control frozen", v, 32'h28);
    // R4 same value ignored, new value reloads
    rd(3'd2, a);
    wr(3'd4, 32'h1234); idle(D + 1);
    rd(3'd2, b); chk("R4 same value no reload", 32'(b > a), 1);
    wr(3'd4, ~32'h1234); idle(D + 1);
    rd(3'd2, v); chk("R4 new value reload", 32'(v <= 32'h102 && v >= 32'h100), 1);
    rd(3'd4, v); chk("R4 trigger readback", v, ~32'h1234);
    // R3 bad sequences
    key(32'hAAAA, 32'h1111);
    wr(3'd5, 32'h5555); idle(D + 1);
    key(32'hAAAA, 32'h4444);
    rd(3'd2, a); idle(8); rd(3'd2, b);
    chk("R3 still running", 32'(b > a), 1);
    // R2 stop
    key(32'hAAAA, 32'h5555);
    rd(3'd2, a); idle(10); rd(3'd2, b);
    chk("R2 stopped hold", b, a);
    // R5 write to pending register dropped
    @(posedge clk); #1; bus_we = 1; bus_addr = 3'd3; bus_wdata = 32'h10;
    @(posedge clk); #1; bus_wdata = 32'h20;
    @(posedge clk); #1; bus_we = 0; bus_addr = 3'd2;
    idle(D + 1);
    rd(3'd3, v); chk("R5 colliding write dropped", v, 32'h10);
    // R9 overflow
    wr(3'd1, 32'h0); idle(D + 1);
    wr(3'd3, 32'hFFFF_FFF8); idle(D + 1);
    wr(3'd4, 32'h55); idle(D + 1);
    rd(3'd2, v); chk("R4 reload high value", v, 32'hFFFF_FFF8);
    tick_mode = 1;
    key(32'hBBBB, 32'h4444);
    idle(80);
    chk("R9 reset pulses seen", 32'(rst_seen > 0), 1);
    rd(3'd2, v); chk("R9 counter reloaded", 32'(v >= 32'hFFFF_FFF8), 1);
    key(32'hAAAA, 32'h5555);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule